// File: doc/BRIEF.md
# Double-Buffered Multichannel Attenuation Register Bank

This block holds the digital attenuation codes for eight audio output channels, arranged as four left/right output pairs. A control path writes it one word at a time through a single-cycle strobe that carries a 7-bit address and a 9-bit data word. The low eight data bits are an attenuation code in half-decibel steps. The code 0xFF means no attenuation. The top data bit is a commit request, and no register stores it.

Every channel has two latches. The first is a pending latch that writes fill. The second is a live latch that drives the channel's output code. A write with the commit request clear only changes pending values. A write with the commit request set also copies all eight pending values into the live latches on the same clock edge, so that several channels change gain together. A broadcast address loads one code into every channel's pending latch. The block also brings out each channel's pending value for readback, and it gives a one-cycle pulse for each commit.

The write path has no back-pressure: there is no ready signal, and every strobe is taken on the clock edge where it is sampled. Reset is synchronous and active-low.

Top module: `atten_bank`

## Requirements
- R1: While rst_n is low at a clock edge, every pending and live code becomes 0xFF and commit_pulse becomes 0.
- R2: Channel index i (0..7) sits at address 0x0B+i. The order is left 1, right 1, left 2, right 2, left 3, right 3, left 4, right 4. Channel i uses bits [8*i+7 : 8*i] of pend_codes and of live_codes.
- R3: A write to a channel address with wr_data[8]=0 loads wr_data[7:0] into that channel's pending latch only. Every live code, and every other pending code, keeps its value.
- R4: A write with wr_data[8]=1 to a valid address updates the pending latch or latches as for a write with the bit clear. On the same edge it copies all eight pending values, including the newly written ones, into the live latches. The new live codes are visible in the cycle after the strobe.
- R5: A write to the broadcast address 0x13 loads wr_data[7:0] into all eight pending latches. wr_data[8] applies in the same way as in R3 and R4.
- R6: A strobe to any other address changes no pending or live code and raises no commit_pulse, even when wr_data[8]=1.
- R7: commit_pulse is high for exactly the one cycle after each committing write, and low in every other cycle.
- R8: Bit 8 of the data word is never stored: the pending readback equals wr_data[7:0] alone.
- R9: Writes on consecutive cycles each take effect in order. A commit uses the pending values as they stand after that edge's own write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 7 | Register address |
| wr_data | input | 9 | Bit 8 is the commit request; bits 7:0 are the code |
| pend_codes | output | 64 | Pending code of each channel, 8 bits per channel |
| live_codes | output | 64 | Active code of each channel, 8 bits per channel |
| commit_pulse | output | 1 | High for one cycle after a commit |

## Verification
Every result of a strobe is due one cycle after the edge that samples it. This covers the pending codes, the live codes and commit_pulse, because the block has one register stage between the write port and all of them. The driver applies inputs on the falling edge and pushes the modelled state that the next rising edge should produce. The monitor pops one item per cycle, shortly after each rising edge, and compares all three outputs. Idle cycles are pushed too, so a value that changes late or a pulse that lasts too long shows up as a miscompare.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int unsigned NUM_CH    = 8;
  localparam int unsigned CODE_W    = 8;
  localparam int unsigned ADDR_W    = 7;
  localparam int unsigned DATA_W    = CODE_W + 1;
  localparam logic [CODE_W-1:0] CODE_RESET = '1;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              commit_req;
  } wr_word_t;

  function automatic wr_word_t split_word(input logic [DATA_W-1:0] d);
    wr_word_t w;
    w.code       = d[CODE_W-1:0];
    w.commit_req = d[CODE_W];
    return w;
  endfunction
endpackage

// File: rtl/atten_addr_decode.sv
module atten_addr_decode #(
  parameter int unsigned NCH   = 8,
  parameter int unsigned AW    = 7,
  parameter logic [6:0]  BASE  = 7'h0B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          commit_req,
  output logic [NCH-1:0] load_sel,
  output logic          commit
);
  localparam logic [AW-1:0] BCAST = AW'(BASE) + AW'(NCH);

  logic           bcast_hit;
  logic [NCH-1:0] ch_hit;

  assign bcast_hit = wr_en && (wr_addr == BCAST);

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    assign ch_hit[i]   = wr_en && (wr_addr == AW'(BASE) + AW'(i));
    assign load_sel[i] = ch_hit[i] || bcast_hit;
  end

  assign commit = commit_req && (bcast_hit || (|ch_hit));

  // R2: a non-broadcast address selects at most one channel
  assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bcast_hit |-> $onehot0(load_sel));

  // R6: nothing is selected without a strobe
  assert_no_sel_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (load_sel == '0 && !commit));
endmodule

// File: rtl/atten_chan_latch.sv
module atten_chan_latch #(
  parameter int unsigned CW = 8,
  parameter logic [7:0]  RST_CODE = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          commit,
  input  logic [CW-1:0] din,
  output logic [CW-1:0] pend_q,
  output logic [CW-1:0] live_q
);
  logic [CW-1:0] pend_nxt;

  assign pend_nxt = load ? din : pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= CW'(RST_CODE);
      live_q <= CW'(RST_CODE);
    end else begin
      pend_q <= pend_nxt;
      if (commit) live_q <= pend_nxt;
    end
  end

  // R3: the live code holds unless a commit was requested
  assert_live_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(live_q));

  // R6: the pending code holds unless this channel was loaded
  assert_pend_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(pend_q));

  // R4: after a commit the live code matches the pending code
  assert_commit_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (live_q == pend_q));
endmodule

// File: rtl/atten_bank.sv
module atten_bank
  import atten_pkg::*;
#(
  parameter int unsigned NCH  = NUM_CH,
  parameter int unsigned CW   = CODE_W,
  parameter int unsigned AW   = ADDR_W,
  parameter logic [6:0]  BASE = 7'h0B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [CW:0]       wr_data,
  output logic [NCH*CW-1:0] pend_codes,
  output logic [NCH*CW-1:0] live_codes,
  output logic              commit_pulse
);
  localparam logic [AW-1:0] BCAST = AW'(BASE) + AW'(NCH);

  logic [NCH-1:0] load_sel;
  logic           commit;
  logic [CW-1:0]  code_in;
  logic           commit_req;

  assign code_in    = wr_data[CW-1:0];
  assign commit_req = wr_data[CW];

  atten_addr_decode #(.NCH(NCH), .AW(AW), .BASE(BASE)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .commit_req (commit_req),
    .load_sel   (load_sel),
    .commit     (commit)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    atten_chan_latch #(.CW(CW), .RST_CODE(CODE_RESET)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load_sel[i]),
      .commit (commit),
      .din    (code_in),
      .pend_q (pend_codes[i*CW +: CW]),
      .live_q (live_codes[i*CW +: CW])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) commit_pulse <= 1'b0;
    else        commit_pulse <= commit;
  end

  // R7: a pulse follows only a committing write to a decoded address
  assert_pulse_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |-> $past(wr_en && wr_data[CW] &&
                           (wr_addr >= AW'(BASE)) && (wr_addr <= BCAST)));

  // R4: right after a commit all live codes equal the pending codes
  assert_commit_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |-> (live_codes == pend_codes));

  // R5: a broadcast write leaves every pending code equal to the written code
  assert_bcast_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == BCAST) |=> (pend_codes == {NCH{$past(wr_data[CW-1:0])}}));
endmodule

// File: tb/atten_bank_tb.sv
module atten_bank_tb;
  localparam int NCH = 8;
  localparam int CW  = 8;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           wr_en;
  logic [6:0]     wr_addr;
  logic [8:0]     wr_data;
  logic [NCH*CW-1:0] pend_codes, live_codes;
  logic           commit_pulse;

  always #5 clk = ~clk;

  atten_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pend_codes(pend_codes), .live_codes(live_codes),
    .commit_pulse(commit_pulse)
  );

  typedef struct {
    logic [NCH*CW-1:0] pend;
    logic [NCH*CW-1:0] live;
    logic              pulse;
    string             req;
  } exp_t;

  exp_t exp_q[$];
  logic [CW-1:0] m_pend [NCH];
  logic [CW-1:0] m_live [NCH];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  function automatic logic [NCH*CW-1:0] pack(input logic [CW-1:0] a [NCH]);
    logic [NCH*CW-1:0] r;
    for (int i = 0; i < NCH; i++) r[i*CW +: CW] = a[i];
    return r;
  endfunction

  task automatic cyc(input logic rst, input logic en, input logic [6:0] a,
                     input logic [8:0] d, input string req);
    exp_t e;
    logic hit;
    @(negedge clk);
    rst_n = ~rst; wr_en = en; wr_addr = a; wr_data = d;
    hit = 1'b0;
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin m_pend[i] = 8'hFF; m_live[i] = 8'hFF; end
    end else if (en) begin
      for (int i = 0; i < NCH; i++)
        if (a == 7'h0B + 7'(i) || a == 7'h13) begin m_pend[i] = d[7:0]; hit = 1'b1; end
      if (hit && d[8])
        for (int i = 0; i < NCH; i++) m_live[i] = m_pend[i];
    end
    e.pend = pack(m_pend); e.live = pack(m_live);
    e.pulse = !rst && hit && d[8]; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n, input string req);
    for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, 7'h00, 9'h000, req);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk); #2;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        checks++;
        if (pend_codes !== e.pend || live_codes !== e.live || commit_pulse !== e.pulse) begin
          fails++;
          $display("FAIL %s: pend=%h live=%h pulse=%b expected pend=%h live=%h pulse=%b",
                   e.req, pend_codes, live_codes, commit_pulse, e.pend, e.live, e.pulse);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    cyc(1'b1, 1'b0, 7'h00, 9'h000, "R1 reset");
    cyc(1'b1, 1'b0, 7'h00, 9'h000, "R1 reset");
    idle(2, "R1 idle after reset");
    // R2/R3/R8: stage each channel, bit 8 clear
    for (int i = 0; i < NCH; i++)
      cyc(1'b0, 1'b1, 7'h0B + 7'(i), {1'b0, 8'(8'h10 + 8'(i))}, "R2 R3 R8 stage per channel");
    idle(1, "R3 live unchanged");
    // R4/R9: commit with new value written on same edge
    cyc(1'b0, 1'b1, 7'h0E, 9'h1A5, "R4 R9 commit with new value");
    idle(2, "R7 pulse single cycle");
    // R6: unlisted addresses with commit bit
    cyc(1'b0, 1'b1, 7'h0A, 9'h133, "R6 below range ignored");
    cyc(1'b0, 1'b1, 7'h14, 9'h144, "R6 above range ignored");
    cyc(1'b0, 1'b1, 7'h7F, 9'h155, "R6 far address ignored");
    cyc(1'b0, 1'b0, 7'h0B, 9'h155, "R6 strobe low ignored");
    // R5: broadcast stage then broadcast commit
    cyc(1'b0, 1'b1, 7'h13, 9'h040, "R5 broadcast stage");
    idle(1, "R5 live held");
    cyc(1'b0, 1'b1, 7'h12, 9'h001, "R9 back-to-back stage");
    cyc(1'b0, 1'b1, 7'h13, 9'h180, "R5 broadcast commit");
    cyc(1'b0, 1'b1, 7'h0C, 9'h1FE, "R7 R9 consecutive commits");
    cyc(1'b0, 1'b1, 7'h0D, 9'h000, "R3 R9 stage after commit");
    idle(1, "R7 pulse ends");
    // R8: bit 8 never lands in code
    cyc(1'b0, 1'b1, 7'h11, 9'h100, "R8 code zero with commit");
    idle(1, "R8 hold");
    // R1: reset mid-run restores 0xFF
    cyc(1'b1, 1'b1, 7'h13, 9'h122, "R1 reset beats write");
    idle(2, "R1 after reset");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule